// File: doc/BRIEF.md
# Shared Single-Port Scratchpad Access Multiplexer

The block joins two single-ported scratch memories, a data bank and an instruction bank of 4 KB each, to three requesters. The requesters are a host CPU bus port, the local coprocessor's load/store port and a DMA engine port. Host accesses use a byte address: bit 12 picks the bank and bits 11:2 pick the 32-bit word. The coprocessor and DMA ports give a bank bit and a word index directly. Every port sees synchronous-RAM timing, so read data appears one clock after the request.

There is no real arbiter. On each bank the requesters are served by fixed precedence: host first, then DMA, then coprocessor. A requester that loses is not held off or retried. A losing write is dropped. A losing read gets back the word read at the winner's address. When the host touches the bank that an active DMA transfer is using, the block tells the DMA engine to reload its running address with the host's word index. This reproduces the corruption that the shared port causes in practice. A per-bank collision flag makes every such clash visible one cycle later.

Top module: `spad_share_mux`

## Requirements
- R1: Host byte address bit 12 selects the bank (0 = data bank, 1 = instruction bank), bits 11:2 select the word, and bits 1:0 have no effect on which word is accessed.
- R2: Each port's read data equals the bank word that the winning access on that bank addressed, as it was before any write in that cycle. It is presented in the clock cycle after the request.
- R3: A write from the winning requester is stored, and any port can read it back afterwards at the same bank and word.
- R4: When the host and the coprocessor hit the same bank in one cycle, the host access is carried out and the coprocessor write is discarded.
- R5: When the host and the coprocessor both hit the same bank in one cycle, the coprocessor read data is the word at the host's address.
- R6: When the host hits the bank that an enabled DMA request is using, then one cycle later `dmaRedirect` is 1 and `dmaRedirAddr` holds the host's word index. The DMA write of that cycle is discarded.
- R7: With no host access on a bank, a DMA request beats a coprocessor request. The coprocessor write is dropped and the coprocessor read returns the word at the DMA address.
- R8: Requests to different banks in the same cycle do not interfere: each is carried out and no collision is flagged.
- R9: `collision[b]` is 1 for exactly the cycle after a cycle in which two or more requesters hit bank b, and 0 otherwise.
- R10: After reset all read data outputs, `collision` and `dmaRedirect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostEn | input | 1 | Host request this cycle |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | 13 | Host byte offset into the scratch window |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, one cycle after the request |
| copEn | input | 1 | Coprocessor load/store request |
| copWe | input | 1 | Coprocessor write (1) or read (0) |
| copBank | input | 1 | Coprocessor bank (0 data, 1 instruction) |
| copAddr | input | 10 | Coprocessor word index |
| copWdata | input | 32 | Coprocessor write data |
| copRdata | output | 32 | Coprocessor read data |
| dmaEn | input | 1 | DMA engine request (transfer active) |
| dmaWe | input | 1 | DMA write into the bank (1) or read (0) |
| dmaBank | input | 1 | DMA bank (0 data, 1 instruction) |
| dmaAddr | input | 10 | DMA running word index |
| dmaWdata | input | 32 | DMA write data |
| dmaRdata | output | 32 | DMA read data |
| collision | output | 2 | Per-bank clash flag, bit 0 data bank, bit 1 instruction bank |
| dmaRedirect | output | 1 | DMA running address must be reloaded |
| dmaRedirAddr | output | 10 | Word index to reload into the DMA engine |

## Verification
The bench targets same-cycle clashes on one bank. A design that queued or reordered the losing coprocessor write would show a changed word on a later read. A design that routed each port to its own address would return the coprocessor's own word where the host's word is expected. Host accesses that land on a busy DMA bank are checked for the redirect strobe and index, since a design keyed on the wrong bank would miss them or raise them for the other bank. Host reads with nonzero low address bits, and cross-bank traffic in the same cycle, catch decoders that alias words or flag clashes that never happened.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOST = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_COP  = 2'd3
  } src_e;

  localparam int NUM_BANKS = 2;

  // Strobes from control to datapath, one lane per bank
  typedef struct packed {
    src_e [NUM_BANKS-1:0] sel;
    logic [NUM_BANKS-1:0] wr;
    logic [NUM_BANKS-1:0] clash;
    logic                 redirect;
  } ctl_t;
endpackage

// File: rtl/spad_ctl.sv
module spad_ctl
  import spad_pkg::*;
(
  input  logic hostEn,
  input  logic hostWe,
  input  logic hostBank,
  input  logic dmaEn,
  input  logic dmaWe,
  input  logic dmaBank,
  input  logic copEn,
  input  logic copWe,
  input  logic copBank,
  output ctl_t strb
);
  always_comb begin
    strb = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic hHit, dHit, cHit;
      hHit = hostEn && (int'(hostBank) == b);
      dHit = dmaEn  && (int'(dmaBank)  == b);
      cHit = copEn  && (int'(copBank)  == b);
      if (hHit) begin
        strb.sel[b] = SRC_HOST;
        strb.wr[b]  = hostWe;
      end else if (dHit) begin
        strb.sel[b] = SRC_DMA;
        strb.wr[b]  = dmaWe;
      end else if (cHit) begin
        strb.sel[b] = SRC_COP;
        strb.wr[b]  = copWe;
      end
      strb.clash[b] = (hHit && dHit) || (hHit && cHit) || (dHit && cHit);
    end
    strb.redirect = hostEn && dmaEn && (hostBank == dmaBank);
  end
endmodule

// File: rtl/spad_dp.sv
module spad_dp
  import spad_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               strb,
  input  logic [WORD_AW-1:0] hostWord,
  input  logic               hostBank,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [WORD_AW-1:0] dmaAddr,
  input  logic               dmaBank,
  input  logic [DATA_W-1:0]  dmaWdata,
  input  logic [WORD_AW-1:0] copAddr,
  input  logic               copBank,
  input  logic [DATA_W-1:0]  copWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic [DATA_W-1:0]  dmaRdata,
  output logic [DATA_W-1:0]  copRdata,
  output logic [NUM_BANKS-1:0] collision,
  output logic               dmaRedirect,
  output logic [WORD_AW-1:0] dmaRedirAddr
);
  localparam int WORDS = 1 << WORD_AW;

  logic [NUM_BANKS-1:0][DATA_W-1:0] rdBank;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [DATA_W-1:0]  mem [WORDS];
    logic [DATA_W-1:0]  rdQ;
    logic [WORD_AW-1:0] portAddr;
    logic [DATA_W-1:0]  portWdata;

    always_comb begin
      unique case (strb.sel[g])
        SRC_HOST: begin portAddr = hostWord; portWdata = hostWdata; end
        SRC_DMA:  begin portAddr = dmaAddr;  portWdata = dmaWdata;  end
        SRC_COP:  begin portAddr = copAddr;  portWdata = copWdata;  end
        default:  begin portAddr = '0;       portWdata = '0;        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (strb.sel[g] != SRC_NONE && strb.wr[g]) mem[portAddr] <= portWdata;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     rdQ <= '0;
      else if (strb.sel[g] != SRC_NONE) rdQ <= mem[portAddr];
    end

    assign rdBank[g] = rdQ;
  end

  logic hostBankQ, dmaBankQ, copBankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostBankQ    <= 1'b0;
      dmaBankQ     <= 1'b0;
      copBankQ     <= 1'b0;
      collision    <= '0;
      dmaRedirect  <= 1'b0;
      dmaRedirAddr <= '0;
    end else begin
      hostBankQ   <= hostBank;
      dmaBankQ    <= dmaBank;
      copBankQ    <= copBank;
      collision   <= strb.clash;
      dmaRedirect <= strb.redirect;
      if (strb.redirect) dmaRedirAddr <= hostWord;
    end
  end

  assign hostRdata = rdBank[hostBankQ];
  assign dmaRdata  = rdBank[dmaBankQ];
  assign copRdata  = rdBank[copBankQ];
endmodule

// File: rtl/spad_share_mux.sv
module spad_share_mux
  import spad_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 10,
  localparam int HOST_AW = WORD_AW + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostEn,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  input  logic               copEn,
  input  logic               copWe,
  input  logic               copBank,
  input  logic [WORD_AW-1:0] copAddr,
  input  logic [DATA_W-1:0]  copWdata,
  output logic [DATA_W-1:0]  copRdata,
  input  logic               dmaEn,
  input  logic               dmaWe,
  input  logic               dmaBank,
  input  logic [WORD_AW-1:0] dmaAddr,
  input  logic [DATA_W-1:0]  dmaWdata,
  output logic [DATA_W-1:0]  dmaRdata,
  output logic [NUM_BANKS-1:0] collision,
  output logic               dmaRedirect,
  output logic [WORD_AW-1:0] dmaRedirAddr
);
  logic               hostBank;
  logic [WORD_AW-1:0] hostWord;
  logic               unusedByteBits;
  ctl_t               strb;

  assign hostBank       = hostAddr[HOST_AW-1];
  assign hostWord       = hostAddr[HOST_AW-2:2];
  assign unusedByteBits = ^hostAddr[1:0];

  spad_ctl uCtl (
    .hostEn(hostEn), .hostWe(hostWe), .hostBank(hostBank),
    .dmaEn(dmaEn),   .dmaWe(dmaWe),   .dmaBank(dmaBank),
    .copEn(copEn),   .copWe(copWe),   .copBank(copBank),
    .strb(strb)
  );

  spad_dp #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWord(hostWord), .hostBank(hostBank), .hostWdata(hostWdata),
    .dmaAddr(dmaAddr), .dmaBank(dmaBank), .dmaWdata(dmaWdata),
    .copAddr(copAddr), .copBank(copBank), .copWdata(copWdata),
    .hostRdata(hostRdata), .dmaRdata(dmaRdata), .copRdata(copRdata),
    .collision(collision), .dmaRedirect(dmaRedirect),
    .dmaRedirAddr(dmaRedirAddr)
  );
endmodule

// File: rtl/spad_share_mux_chk.sv
module spad_share_mux_chk #(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 10,
  localparam int HOST_AW = WORD_AW + 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostEn,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               copEn,
  input logic               copBank,
  input logic               dmaEn,
  input logic               dmaBank,
  input logic [1:0]         collision,
  input logic               dmaRedirect,
  input logic [WORD_AW-1:0] dmaRedirAddr,
  input logic [DATA_W-1:0]  hostRdata
);
  logic hb;
  assign hb = hostAddr[HOST_AW-1];

  // R9: a data-bank flag needs two requesters on that bank one cycle earlier
  assert_clash_d_R9: assert property (@(posedge clk) disable iff (!rstN)
    collision[0] |-> $past($countones({hostEn && !hb, dmaEn && !dmaBank, copEn && !copBank}) >= 2));

  // R9: the same for the instruction bank
  assert_clash_i_R9: assert property (@(posedge clk) disable iff (!rstN)
    collision[1] |-> $past($countones({hostEn && hb, dmaEn && dmaBank, copEn && copBank}) >= 2));

  // R6: redirect only after the host met an active DMA on its bank
  assert_redirect_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaRedirect |-> $past(hostEn && dmaEn && (hb == dmaBank)));

  // R6: the reload index is the host's word index
  assert_redirect_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaRedirect |-> dmaRedirAddr == $past(hostAddr[HOST_AW-2:2]));

  // R8: host and coprocessor on different banks with DMA idle never clash
  assert_cross_bank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && copEn && !dmaEn && (copBank != hb)) |=> (collision == 2'b00));

  // R10: outputs leave reset cleared
  assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (collision == 2'b00 && !dmaRedirect && hostRdata == '0));
endmodule

bind spad_share_mux spad_share_mux_chk #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) uChk (.*);

// File: tb/sim_spad_share_mux.sv
`timescale 1ns/1ps
module sim_spad_share_mux;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostEn = 0, hostWe = 0;
  logic [12:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        copEn = 0, copWe = 0, copBank = 0;
  logic [9:0]  copAddr = '0;
  logic [31:0] copWdata = '0;
  logic [31:0] copRdata;
  logic        dmaEn = 0, dmaWe = 0, dmaBank = 0;
  logic [9:0]  dmaAddr = '0;
  logic [31:0] dmaWdata = '0;
  logic [31:0] dmaRdata;
  logic [1:0]  collision;
  logic        dmaRedirect;
  logic [9:0]  dmaRedirAddr;

  int nChecks = 0;
  int nErr = 0;
  logic [31:0] model [2][1024];

  always #10 clk = ~clk;

  spad_share_mux u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] hAddr(logic bank, logic [9:0] word, logic [1:0] lo);
    return {bank, word, lo};
  endfunction

  task automatic idle();
    hostEn = 0; copEn = 0; dmaEn = 0;
    hostWe = 0; copWe = 0; dmaWe = 0;
  endtask

  // One clock of traffic: predict from the requirements, clock, then compare
  task automatic cycle(bit doChk);
    logic [1:0] hH, dH, cH, expCol;
    int win [2];
    int wAddr [2];
    logic [31:0] expH, expD, expC;
    logic expRedir;
    logic [9:0] expRA;
    string tagC, tagD, tagH;
    for (int b = 0; b < 2; b++) begin
      hH[b] = hostEn && (int'(hostAddr[12]) == b);
      dH[b] = dmaEn && (int'(dmaBank) == b);
      cH[b] = copEn && (int'(copBank) == b);
      if (hH[b])      begin win[b] = 1; wAddr[b] = int'(hostAddr[11:2]); end
      else if (dH[b]) begin win[b] = 2; wAddr[b] = int'(dmaAddr); end
      else if (cH[b]) begin win[b] = 3; wAddr[b] = int'(copAddr); end
      else            begin win[b] = 0; wAddr[b] = 0; end
      expCol[b] = (hH[b] && dH[b]) || (hH[b] && cH[b]) || (dH[b] && cH[b]);
    end
    expH = model[hostAddr[12]][wAddr[hostAddr[12]]];
    expD = model[dmaBank][wAddr[dmaBank]];
    expC = model[copBank][wAddr[copBank]];
    expRedir = hostEn && dmaEn && (hostAddr[12] == dmaBank);
    expRA = hostAddr[11:2];
    tagH = (hostAddr[1:0] != 0) ? "R1" : "R2";
    tagC = hH[copBank] ? "R5" : (dH[copBank] ? "R7" : (hostEn ? "R8" : "R2"));
    tagD = hH[dmaBank] ? "R6" : "R2";
    for (int b = 0; b < 2; b++) begin
      if (win[b] == 1 && hostWe) model[b][wAddr[b]] = hostWdata;
      if (win[b] == 2 && dmaWe)  model[b][wAddr[b]] = dmaWdata;
      if (win[b] == 3 && copWe)  model[b][wAddr[b]] = copWdata;
    end
    @(posedge clk);
    @(negedge clk);
    if (doChk) begin
      if (hostEn && !hostWe) chk(tagH, hostRdata, expH);
      if (copEn && !copWe)   chk(tagC, copRdata, expC);
      if (dmaEn && !dmaWe)   chk(tagD, dmaRdata, expD);
      chk("R9", {30'b0, collision}, {30'b0, expCol});
      chk("R6", {31'b0, dmaRedirect}, {31'b0, expRedir});
      if (expRedir) chk("R6", {22'b0, dmaRedirAddr}, {22'b0, expRA});
    end
  endtask

  task automatic hostRead(logic bank, logic [9:0] word, string tag);
    idle();
    hostEn = 1; hostAddr = hAddr(bank, word, 2'b00);
    @(posedge clk);
    @(negedge clk);
    chk(tag, hostRdata, model[bank][word]);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    chk("R10", hostRdata, 32'h0);
    chk("R10", {30'b0, collision}, 32'h0);
    chk("R10", {31'b0, dmaRedirect}, 32'h0);

    // Preload every word via host writes
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 1024; w++) begin
        idle();
        hostEn = 1; hostWe = 1;
        hostAddr = hAddr(b[0], w[9:0], 2'b00);
        hostWdata = {b[7:0], 8'h5a, w[15:0]} ^ 32'h3c3c_0000;
        cycle(0);
      end
    idle();

    // R1/R3: bank selection and low bits ignored
    hostEn = 1; hostWe = 1; hostAddr = hAddr(1, 10'd1, 2'b00); hostWdata = 32'hAAAA_0001;
    cycle(1);
    hostAddr = hAddr(0, 10'd1, 2'b11); hostWdata = 32'hBBBB_0001;
    cycle(1);
    idle();
    copEn = 1; copBank = 1; copAddr = 10'd1;
    cycle(1);
    chk("R1", copRdata, 32'hAAAA_0001);
    idle();
    hostEn = 1; hostAddr = hAddr(1, 10'd1, 2'b10);
    cycle(1);
    chk("R1", hostRdata, 32'hAAAA_0001);
    hostRead(0, 10'd1, "R3");
    chk("R3", hostRdata, 32'hBBBB_0001);

    // R4: host and coprocessor writes collide on one word
    idle();
    hostEn = 1; hostWe = 1; hostAddr = hAddr(0, 10'd5, 2'b00); hostWdata = 32'h1111_1111;
    copEn = 1; copWe = 1; copBank = 0; copAddr = 10'd5; copWdata = 32'h2222_2222;
    cycle(1);
    hostRead(0, 10'd5, "R4");
    chk("R4", hostRdata, 32'h1111_1111);
    // R4: coprocessor write to another word dropped while host reads
    hostEn = 1; hostAddr = hAddr(0, 10'd5, 2'b00);
    copEn = 1; copWe = 1; copBank = 0; copAddr = 10'd6; copWdata = 32'hDEAD_BEEF;
    cycle(1);
    hostRead(0, 10'd6, "R4");

    // R5: both read, different words, coprocessor gets the host word
    hostEn = 1; hostAddr = hAddr(0, 10'd7, 2'b00);
    copEn = 1; copBank = 0; copAddr = 10'd9;
    cycle(1);
    chk("R5", copRdata, model[0][7]);

    // R6: host meets active DMA write on the instruction bank
    idle();
    dmaEn = 1; dmaWe = 1; dmaBank = 1; dmaAddr = 10'd3; dmaWdata = 32'h7777_7777;
    hostEn = 1; hostAddr = hAddr(1, 10'd20, 2'b00);
    cycle(1);
    chk("R6", {22'b0, dmaRedirAddr}, 32'd20);
    hostRead(1, 10'd3, "R6");

    // R7: DMA beats coprocessor without host
    dmaEn = 1; dmaBank = 0; dmaAddr = 10'd2;
    copEn = 1; copWe = 1; copBank = 0; copAddr = 10'd4; copWdata = 32'h4444_4444;
    cycle(1);
    hostRead(0, 10'd4, "R7");
    dmaEn = 1; dmaBank = 0; dmaAddr = 10'd2;
    copEn = 1; copBank = 0; copAddr = 10'd8;
    cycle(1);
    chk("R7", copRdata, model[0][2]);

    // R8: host and coprocessor writes on different banks both land
    idle();
    hostEn = 1; hostWe = 1; hostAddr = hAddr(0, 10'd12, 2'b00); hostWdata = 32'h0C0C_0C0C;
    copEn = 1; copWe = 1; copBank = 1; copAddr = 10'd12; copWdata = 32'h1C1C_1C1C;
    cycle(1);
    chk("R8", {30'b0, collision}, 32'h0);
    hostRead(0, 10'd12, "R8");
    hostRead(1, 10'd12, "R8");

    // Random mix on a small window of words
    for (int i = 0; i < 4000; i++) begin
      hostEn = $urandom_range(0, 1); hostWe = $urandom_range(0, 1);
      hostAddr = hAddr($urandom_range(0, 1), 10'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
      hostWdata = $urandom;
      copEn = $urandom_range(0, 1); copWe = $urandom_range(0, 1);
      copBank = $urandom_range(0, 1); copAddr = 10'($urandom_range(0, 7)); copWdata = $urandom;
      dmaEn = $urandom_range(0, 1); dmaWe = $urandom_range(0, 1);
      dmaBank = $urandom_range(0, 1); dmaAddr = 10'($urandom_range(0, 7)); dmaWdata = $urandom;
      cycle(1);
    end
    idle();
    for (int w = 0; w < 8; w++) begin
      hostRead(0, 10'(w), "R3");
      hostRead(1, 10'(w), "R3");
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule